// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block is a peripheral timer with three independent 32-bit down-counting channels behind a single-cycle register port. A shared run register holds one run bit per channel. Each channel owns a reload value, a live count and a 16-bit control word that picks the tick divider and the interrupt enable, and holds a sticky underflow flag.

While its run bit is set, a channel's own prescaler divides the clock by 4, 16, 64 or 256. Each divided tick decrements the count. A tick that finds the count at zero loads the reload value instead, sets the flag and, if enabled, raises that channel's interrupt line. Two settings are typical. A reload of all ones with a count of all ones gives a free-running time base, whose elapsed ticks are the inverse of the count. A reload equal to the interval gives a periodic event source.

Software acknowledges an event by writing the control word with the flag bit at zero. Writing the same word with the flag bit at one leaves the flag as it is.

Top module: `reload_timer`

## Requirements
- R1: After reset the run register reads 0, every reload and count register reads 0xFFFFFFFF, every control word reads 0 and all interrupt lines are low.
- R2: Byte address 0x00 holds the run register, with bit n running channel n. Run bits at or above the channel count read 0. Channel n occupies 0x04+12n (reload), 0x08+12n (count) and 0x0C+12n (control). Control reads return zeros above bit 15 and in the unused bits 15:9, 7:6 and 4:3. Addresses that are not word aligned or not mapped read 0, and writes to them change nothing.
- R3: A channel whose run bit is clear does not count and keeps its count until it is restarted.
- R4: Control bits 2:0 select the tick divider: code 0 gives 4, 1 gives 16, 2 gives 64 and 3 gives 256, and codes 4 to 7 give 4. The first decrement lands exactly one divider period after the clock edge that sets the run bit, because the prescaler phase restarts at every start.
- R5: Each tick decrements a nonzero count by one. A tick at count zero loads the reload value, so after the first underflow the period is reload+1 ticks.
- R6: Every underflow sets the flag in control bit 8, and the flag stays set until software clears it.
- R7: A control write with bit 8 at zero clears the flag, and one with bit 8 at one leaves it unchanged; no write can set the flag. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: The interrupt line of channel n is high exactly when its flag is set and its control bit 5 (0x0020) is set.
- R9: Writes to the reload and count registers take effect on the next edge whether the channel runs or not. A count write overrides the decrement of that cycle and suppresses its underflow.
- R10: Channels are independent: starting, stopping or configuring one does not change the count, flag or timing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The bench sweeps every divider code on every channel. At each point it compares the count against an arithmetic model of ticks elapsed, counting the exact edge of each run-bit write. A prescaler that kept its phase across a stop, or treated reserved codes as larger dividers, shows up as a count that is off by one tick. A reload that counted reload ticks instead of reload+1 drifts within a few periods.

Further checks stop one channel while two others run, and write the control word with the flag bit at one and at zero. A design that shared run state between channels, cleared the flag on any control write, or let a write set the flag would return the wrong count or flag. Gating the interrupt with the stored enable is tested by dropping the enable while the flag is pending.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

    // Width of each channel's prescale counter (largest divider is 256).
    localparam int PRE_W = 8;

    // Control word layout
    localparam int CTL_W        = 16;
    localparam int CTL_DIV_W    = 3;
    localparam int CTL_IE_BIT   = 5;
    localparam int CTL_FLAG_BIT = 8;

    // Kind of register selected inside a channel block
    typedef enum logic [1:0] {
        KIND_RELOAD = 2'd0,
        KIND_COUNT  = 2'd1,
        KIND_CTRL   = 2'd2,
        KIND_NONE   = 2'd3
    } reg_kind_e;

    // Terminal prescale count for a divider code; reserved codes map to /4.
    function automatic logic [PRE_W-1:0] div_last(input logic [CTL_DIV_W-1:0] code);
        logic [PRE_W-1:0] r;
        case (code)
            3'd1:    r = PRE_W'(15);
            3'd2:    r = PRE_W'(63);
            3'd3:    r = PRE_W'(255);
            default: r = PRE_W'(3);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rt_decode.sv
module rt_decode
    import reload_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              start_hit,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_kind_e         kind
);

    localparam int WORD_W      = ADDR_W - 2;
    localparam int REGS_PER_CH = 3;

    logic [WORD_W-1:0] word;
    logic              aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        start_hit = aligned && (word == '0);
        ch_hit    = '0;
        kind      = KIND_NONE;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < REGS_PER_CH; k++) begin
                if (aligned && (word == WORD_W'(1 + REGS_PER_CH * c + k))) begin
                    ch_hit[c] = 1'b1;
                    kind      = reg_kind_e'(k);
                end
            end
        end
    end

endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler
    import reload_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [CTL_DIV_W-1:0] code,
    output logic                 tick
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = run && (pre_q.phase >= div_last(code));
        if (!run || tick) begin
            pre_d.phase = '0;
        end else begin
            pre_d.phase = pre_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/rt_channel.sv
module rt_channel
    import reload_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_reload,
    input  logic             wr_count,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [CTL_W-1:0] ctrl_o,
    output logic             flag_o,
    output logic             tick_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0]     count;
        logic [CNT_W-1:0]     reload;
        logic [CTL_DIV_W-1:0] div_code;
        logic                 irq_en;
        logic                 flag;
    } chan_state_t;

    chan_state_t ch_d, ch_q;
    logic        tick;

    rt_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .code  (ch_q.div_code),
        .tick  (tick)
    );

    always_comb begin
        ch_d = ch_q;
        if (wr_reload) begin
            ch_d.reload = wdata;
        end
        if (wr_ctrl) begin
            ch_d.div_code = wdata[CTL_DIV_W-1:0];
            ch_d.irq_en   = wdata[CTL_IE_BIT];
            ch_d.flag     = ch_q.flag & wdata[CTL_FLAG_BIT];
        end
        if (wr_count) begin
            ch_d.count = wdata;
        end else if (tick) begin
            if (ch_q.count == '0) begin
                ch_d.count = ch_q.reload;
                ch_d.flag  = 1'b1;
            end else begin
                ch_d.count = ch_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.count    <= '1;
            ch_q.reload   <= '1;
            ch_q.div_code <= '0;
            ch_q.irq_en   <= 1'b0;
            ch_q.flag     <= 1'b0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign count_o  = ch_q.count;
    assign reload_o = ch_q.reload;
    assign ctrl_o   = {7'b0, ch_q.flag, 2'b0, ch_q.irq_en, 2'b0, ch_q.div_code};
    assign flag_o   = ch_q.flag;
    assign tick_o   = tick;
    assign irq_o    = ch_q.flag & ch_q.irq_en;

endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import reload_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] run;
    } top_state_t;

    top_state_t top_d, top_q;

    logic                         start_hit;
    logic [NUM_CH-1:0]            ch_hit;
    reg_kind_e                    kind;

    logic [NUM_CH-1:0]            run_vec;
    logic [NUM_CH-1:0]            tick_vec;
    logic [NUM_CH-1:0]            flag_vec;
    logic [NUM_CH-1:0]            cnt_wr_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_arr;
    logic [NUM_CH-1:0][CNT_W-1:0] rld_arr;
    logic [NUM_CH-1:0][CTL_W-1:0] ctl_arr;

    rt_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr      (bus_addr),
        .start_hit (start_hit),
        .ch_hit    (ch_hit),
        .kind      (kind)
    );

    always_comb begin
        top_d = top_q;
        if (bus_wr && start_hit) begin
            top_d.run = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign run_vec = top_q.run;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic wr_rld, wr_cnt, wr_ctl;
        assign wr_rld        = bus_wr && ch_hit[c] && (kind == KIND_RELOAD);
        assign wr_cnt        = bus_wr && ch_hit[c] && (kind == KIND_COUNT);
        assign wr_ctl        = bus_wr && ch_hit[c] && (kind == KIND_CTRL);
        assign cnt_wr_vec[c] = wr_cnt;

        rt_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_vec[c]),
            .wr_reload (wr_rld),
            .wr_count  (wr_cnt),
            .wr_ctrl   (wr_ctl),
            .wdata     (bus_wdata),
            .count_o   (cnt_arr[c]),
            .reload_o  (rld_arr[c]),
            .ctrl_o    (ctl_arr[c]),
            .flag_o    (flag_vec[c]),
            .tick_o    (tick_vec[c]),
            .irq_o     (irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (start_hit) begin
            bus_rdata = CNT_W'(top_q.run);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) begin
                case (kind)
                    KIND_RELOAD: bus_rdata = rld_arr[c];
                    KIND_COUNT:  bus_rdata = cnt_arr[c];
                    KIND_CTRL:   bus_rdata = CNT_W'(ctl_arr[c]);
                    default:     bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/reload_timer_checker.sv
module rt_checker #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            run_vec,
    input logic [NUM_CH-1:0]            tick_vec,
    input logic [NUM_CH-1:0]            cnt_wr_vec,
    input logic [NUM_CH-1:0]            flag_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_arr,
    input logic [NUM_CH-1:0][CNT_W-1:0] rld_arr,
    input logic [NUM_CH-1:0]            irq
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_halt_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !run_vec[i] |-> !tick_vec[i]);

        assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[i] && !cnt_wr_vec[i]) |=> $stable(cnt_arr[i]));

        assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_vec[i] && !cnt_wr_vec[i] && cnt_arr[i] != '0)
            |=> cnt_arr[i] == $past(cnt_arr[i]) - 1'b1);

        assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_vec[i] && !cnt_wr_vec[i] && cnt_arr[i] == '0)
            |=> (cnt_arr[i] == $past(rld_arr[i])) && flag_vec[i]);

        assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[i]) |-> $past(tick_vec[i] && !cnt_wr_vec[i] && cnt_arr[i] == '0));

        assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> flag_vec[i]);
    end

endmodule

bind reload_timer rt_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_vec    (run_vec),
    .tick_vec   (tick_vec),
    .cnt_wr_vec (cnt_wr_vec),
    .flag_vec   (flag_vec),
    .cnt_arr    (cnt_arr),
    .rld_arr    (rld_arr),
    .irq        (irq)
);

// File: tb/reload_timer_tb.sv
`timescale 1ns/1ps
module reload_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reload_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic int div_of(int code);
        case (code)
            1: return 16;
            2: return 64;
            3: return 256;
            default: return 4;
        endcase
    endfunction

    function automatic int ch_base(int c);
        return 4 + 12 * c;
    endfunction

    // Count after k ticks from start value c with reload value r (R5).
    function automatic logic [31:0] exp_cnt(int c, int r, int k);
        int k2;
        if (k <= c) return 32'(c - k);
        k2 = k - c - 1;
        return 32'(r - (k2 % (r + 1)));
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Starts at a negedge; the write lands on the next rising edge.
    task automatic wr(int addr, logic [31:0] data);
        bus_addr  = 8'(addr);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Combinational read: consumes no clock edge.
    task automatic rchk(string req, int addr, logic [31:0] exp);
        bus_addr = 8'(addr);
        #0.1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rchk("R1 run reg", 0, 32'h0);
        for (int c = 0; c < 3; c++) begin
            rchk("R1 reload", ch_base(c), 32'hFFFF_FFFF);
            rchk("R1 count", ch_base(c) + 4, 32'hFFFF_FFFF);
            rchk("R1 ctrl", ch_base(c) + 8, 32'h0);
        end
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 address map corners
        wr(0, 32'hF8);
        rchk("R2 upper run bits", 0, 32'h0);
        wr(8'h28, 32'h1234_5678);
        wr(ch_base(1) + 5, 32'h0000_0042);
        rchk("R2 unmapped read", 8'h28, 32'h0);
        rchk("R2 misaligned read", ch_base(0) + 1, 32'h0);
        for (int c = 0; c < 3; c++) begin
            rchk("R2 unmapped write", ch_base(c) + 4, 32'hFFFF_FFFF);
            rchk("R2 unmapped write", ch_base(c), 32'hFFFF_FFFF);
        end
        wr(ch_base(0) + 8, 32'hFFFF_FFFF);
        rchk("R2 R7 ctrl readback mask", ch_base(0) + 8, 32'h0000_0027);
        chk("R7 no set by write", 32'(irq), 32'h0);
        wr(ch_base(0) + 8, 32'h0);

        // Sweep: every channel, every divider code (R3 R4 R5 R6 R7 R9)
        for (int c = 0; c < 3; c++) begin
            for (int code = 0; code < 8; code++) begin
                int d, cv, rv, n, k;
                d  = div_of(code);
                cv = code + 1;
                rv = c + 2;
                b  = ch_base(c);
                wr(b + 8, 32'(code));
                wr(b, 32'(rv));
                wr(b + 4, 32'(cv));
                rchk("R9 stopped count write", b + 4, 32'(cv));
                wr(0, 32'(1 << c));
                n = 7 * d + d / 2;
                wait_cyc(n);
                k = n / d;
                rchk("R4 R5 count", b + 4, exp_cnt(cv, rv, k));
                rchk("R6 flag", b + 8, 32'(code) | ((k > cv) ? 32'h100 : 32'h0));
                chk("R8 irq disabled", 32'(irq), 32'h0);
                wr(0, 32'h0);
                wait_cyc(2 * d + 3);
                rchk("R3 halted hold", b + 4, exp_cnt(cv, rv, (n + 1) / d));
                wr(b + 8, 32'(code));
                rchk("R7 flag clear", b + 8, 32'(code));
            end
        end

        // Interrupt handling on channel 1 (R5 R6 R7 R8)
        b = ch_base(1);
        wr(b + 8, 32'h20);
        wr(b, 32'd5);
        wr(b + 4, 32'd0);
        wr(0, 32'h2);
        wait_cyc(4);
        rchk("R5 reload at zero", b + 4, 32'd5);
        chk("R8 irq raised", 32'(irq), 32'h2);
        wr(b + 8, 32'h120);
        rchk("R7 write one keeps flag", b + 8, 32'h120);
        chk("R8 irq kept", 32'(irq), 32'h2);
        wr(b + 8, 32'h20);
        rchk("R7 write zero clears", b + 8, 32'h20);
        chk("R8 irq cleared", 32'(irq), 32'h0);
        wait_cyc(22);
        rchk("R5 period reload+1", b + 4, 32'd5);
        chk("R8 irq again", 32'(irq), 32'h2);
        wr(b + 8, 32'h100);
        rchk("R8 enable off flag held", b + 8, 32'h100);
        chk("R8 irq gated", 32'(irq), 32'h0);
        wr(0, 32'h0);
        wr(b + 8, 32'h0);

        // Prescaler phase restart on channel 0 (R3 R4 R9)
        b = ch_base(0);
        wr(b + 8, 32'h0);
        wr(b + 4, 32'd10);
        wr(0, 32'h1);
        wait_cyc(3);
        rchk("R4 no tick before period", b + 4, 32'd10);
        wait_cyc(1);
        rchk("R4 first tick", b + 4, 32'd9);
        wait_cyc(2);
        wr(0, 32'h0);
        wait_cyc(5);
        rchk("R3 hold after stop", b + 4, 32'd9);
        wr(0, 32'h1);
        wait_cyc(3);
        rchk("R4 phase restarted", b + 4, 32'd9);
        wait_cyc(1);
        rchk("R4 tick after restart", b + 4, 32'd8);
        wr(b + 4, 32'd100);
        rchk("R9 running count write", b + 4, 32'd100);
        wr(b, 32'd7);
        rchk("R9 running reload write", b, 32'd7);
        wr(0, 32'h0);

        // Independence (R10)
        begin
            int cv0, cv1, cv2, rv0, rv1, rv2, n1, n2, k0, k1, k2;
            cv0 = 50; rv0 = 50; cv1 = 30; rv1 = 30; cv2 = 3; rv2 = 2;
            wr(ch_base(0) + 8, 32'h0); wr(ch_base(0), 32'(rv0)); wr(ch_base(0) + 4, 32'(cv0));
            wr(ch_base(1) + 8, 32'h1); wr(ch_base(1), 32'(rv1)); wr(ch_base(1) + 4, 32'(cv1));
            wr(ch_base(2) + 8, 32'h2); wr(ch_base(2), 32'(rv2)); wr(ch_base(2) + 4, 32'(cv2));
            wr(0, 32'h7);
            n1 = 40;
            wait_cyc(n1);
            wr(0, 32'h5);
            n2 = 300;
            wait_cyc(n2);
            k0 = (n1 + 1 + n2) / 4;
            k1 = (n1 + 1) / 16;
            k2 = (n1 + 1 + n2) / 64;
            rchk("R10 ch0 count", ch_base(0) + 4, exp_cnt(cv0, rv0, k0));
            rchk("R10 ch1 held", ch_base(1) + 4, exp_cnt(cv1, rv1, k1));
            rchk("R10 ch2 count", ch_base(2) + 4, exp_cnt(cv2, rv2, k2));
            rchk("R10 ch0 flag", ch_base(0) + 8, (k0 > cv0) ? 32'h100 : 32'h0);
            rchk("R10 ch1 flag", ch_base(1) + 8, 32'h1);
            rchk("R10 ch2 flag", ch_base(2) + 8, 32'h2 | ((k2 > cv2) ? 32'h100 : 32'h0));
            rchk("R10 run reg", 0, 32'h5);
            wr(0, 32'h0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule